// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Flags and Flow Control

This block sits between a host-side register interface and a serial framer. It holds two 16-entry byte queues. The host fills the transmit queue and the framer drains it. The framer fills the receive queue and the host drains it. Each received byte is stored together with two tag bits: one marks a parity error and one marks a framing error. The tags travel through the queue with their byte.

The block derives several flags from the two fill levels, using small encoded tables. The receive threshold flag uses a "greater than or equal" comparison. The transmit threshold flag uses a "less than or equal" comparison. A separate programmable level drives a flow-control output that asks the far end to pause. The block also keeps a running count of the tagged bytes still waiting in the receive queue, and it has a sticky overrun flag. Each queue can be flushed on its own. A loopback mode feeds every byte the framer takes from the transmit queue straight back into the receive queue.

Top module: `serfifo_top`

## Requirements
- R1: The transmit queue returns bytes in write order on `fr_tx_data`, and `fr_tx_avail` is high while it is not empty. It holds 16 bytes. A host write while it holds 16 bytes, with no pop in the same cycle, is dropped.
- R2: The receive queue returns bytes in push order on `host_rx_data`. `host_rx_perr` and `host_rx_ferr` show the tags that were pushed with the head byte.
- R3: A receive push while the queue holds 16 bytes and no pop happens in the same cycle drops the byte and sets `ovr_flag`. The flag stays set until a cycle with `ovr_clear` high and no new drop. A push and a pop together on a full queue are both accepted.
- R4: A push and a pop in the same cycle on a non-empty queue leave that queue's count unchanged.
- R5: `cfg_rx_trig` codes 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes. `rx_full_flag` is high exactly when the receive count is greater than or equal to the selected level.
- R6: `cfg_tx_trig` codes 0, 1, 2 and 3 select 8, 4, 2 and 1 bytes. `tx_empty_flag` is high exactly when the transmit count is less than or equal to the selected level.
- R7: `count_word[12:8]` holds the transmit count and `count_word[4:0]` holds the receive count. All other bits are zero. The counts show the state after the most recent clock edge.
- R8: `rts_stop` is high exactly when `cfg_flow_en` is high and the receive count is strictly greater than `cfg_rts_lvl`.
- R9: `perr_count` and `ferr_count` give the number of bytes in the receive queue whose parity tag (respectively framing tag) is set, saturating at 15.
- R10: `tx_flush` empties the transmit queue at the next edge. A host write or framer pop in the same cycle is ignored.
- R11: `rx_flush` empties the receive queue and zeroes both error counts at the next edge. A push or read in the same cycle is ignored, and `ovr_flag` keeps its value.
- R12: With `cfg_loop` high, every byte popped by the framer is pushed into the receive queue with both tags clear, and `fr_rx_push` is ignored.
- R13: After reset both queues are empty, `tx_empty_flag` is 1, and `rx_full_flag`, `ovr_flag`, `rts_stop` and both error counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_wr | input | 1 | Host writes one transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_rd | input | 1 | Host reads (pops) the receive head |
| host_rx_data | output | 8 | Receive head byte |
| host_rx_perr | output | 1 | Parity tag of receive head |
| host_rx_ferr | output | 1 | Framing tag of receive head |
| fr_tx_pop | input | 1 | Framer takes the transmit head |
| fr_tx_data | output | 8 | Transmit head byte |
| fr_tx_avail | output | 1 | Transmit queue not empty |
| fr_rx_push | input | 1 | Framer delivers a received byte |
| fr_rx_data | input | 8 | Received byte |
| fr_rx_perr | input | 1 | Parity error tag for the received byte |
| fr_rx_ferr | input | 1 | Framing error tag for the received byte |
| cfg_rx_trig | input | 2 | Receive threshold code |
| cfg_tx_trig | input | 2 | Transmit threshold code |
| cfg_rts_lvl | input | 5 | Flow-control level |
| cfg_flow_en | input | 1 | Enables flow-control output |
| cfg_loop | input | 1 | Loopback mode |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue, zero error counts |
| ovr_clear | input | 1 | Clear the overrun flag |
| rx_full_flag | output | 1 | Receive count at or above threshold |
| tx_empty_flag | output | 1 | Transmit count at or below threshold |
| rts_stop | output | 1 | Flow control: ask sender to pause |
| ovr_flag | output | 1 | Sticky overrun |
| count_word | output | 16 | Packed fill counts |
| perr_count | output | 4 | Parity-tagged bytes held |
| ferr_count | output | 4 | Framing-tagged bytes held |

## Verification
The bench sweeps every fill level from empty to full and one past full on both queues. At each level it tries all four threshold codes and every flow-control level. A comparison with the wrong sense, or an off-by-one at the 14-byte or 8-byte entry, therefore shows up as a flag that is wrong at exactly one fill level. The tests overfill the receive queue, and also push and pop together at full, so that a design that drops the paired push or never sets the overrun flag is caught. A receive queue filled entirely with tagged bytes checks the saturation at 15 and the step down as bytes leave. Flushes are issued together with writes, which exposes a design that lets the write survive or clears the overrun flag. Loopback is driven with junk on the framer receive input, which exposes a design that lets that input through.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TAG_W  = 2;   // bit 0 framing, bit 1 parity
    localparam int unsigned RXE_W  = BYTE_W + TAG_W;

    function automatic logic [7:0] rx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd1;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

    function automatic logic [7:0] tx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd8;
            2'd1:    return 8'd4;
            2'd2:    return 8'd2;
            default: return 8'd1;
        endcase
    endfunction
endpackage

// File: rtl/serfifo_store.sv
module serfifo_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        pop_ok  = 1'b0;
        push_ok = 1'b0;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            pop_ok  = pop && (st_q.cnt != '0);
            push_ok = push && ((st_q.cnt != CW'(DEPTH)) || pop_ok);
            if (push_ok) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = bump(st_q.wp);
            end
            if (pop_ok) begin
                st_d.rp = bump(st_q.rp);
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !pop && !flush) |=> count == CW'(DEPTH));
    p_pair_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && push && pop && !flush) |=> $stable(count));
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/serfifo_tagcnt.sv
module serfifo_tagcnt #(
    parameter int unsigned CW   = 5,
    parameter int unsigned OUTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    input  logic            clr,
    output logic [CW-1:0]   full_cnt,
    output logic [OUTW-1:0] sat_cnt
);
    localparam logic [CW-1:0] SAT_MAX = CW'((1 << OUTW) - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        else     st_d.cnt = st_q.cnt + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_cnt = st_q.cnt;
    assign sat_cnt  = (st_q.cnt > SAT_MAX) ? SAT_MAX[OUTW-1:0] : st_q.cnt[OUTW-1:0];

    p_tag_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sat_cnt == '0);
endmodule

// File: rtl/serfifo_top.sv
module serfifo_top
    import serfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_tx_wr,
    input  logic [7:0]  host_tx_data,
    input  logic        host_rx_rd,
    output logic [7:0]  host_rx_data,
    output logic        host_rx_perr,
    output logic        host_rx_ferr,
    input  logic        fr_tx_pop,
    output logic [7:0]  fr_tx_data,
    output logic        fr_tx_avail,
    input  logic        fr_rx_push,
    input  logic [7:0]  fr_rx_data,
    input  logic        fr_rx_perr,
    input  logic        fr_rx_ferr,
    input  logic [1:0]  cfg_rx_trig,
    input  logic [1:0]  cfg_tx_trig,
    input  logic [4:0]  cfg_rts_lvl,
    input  logic        cfg_flow_en,
    input  logic        cfg_loop,
    input  logic        tx_flush,
    input  logic        rx_flush,
    input  logic        ovr_clear,
    output logic        rx_full_flag,
    output logic        tx_empty_flag,
    output logic        rts_stop,
    output logic        ovr_flag,
    output logic [15:0] count_word,
    output logic [3:0]  perr_count,
    output logic [3:0]  ferr_count
);
    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [BYTE_W-1:0] tx_head;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic              rx_push_src;
    logic [RXE_W-1:0]  rx_wdata, rx_head;
    logic [CW-1:0]     tag_full [TAG_W];
    logic [3:0]        tag_sat  [TAG_W];

    serfifo_store #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(host_tx_wr), .pop(fr_tx_pop), .flush(tx_flush),
        .wdata(host_tx_data), .rdata(tx_head), .count(tx_cnt),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    // Loopback: framer transmit pops feed the receive queue, tags clear.
    always_comb begin
        if (cfg_loop) begin
            rx_push_src = tx_pop_ok;
            rx_wdata    = {2'b00, tx_head};
        end else begin
            rx_push_src = fr_rx_push;
            rx_wdata    = {fr_rx_perr, fr_rx_ferr, fr_rx_data};
        end
    end

    serfifo_store #(.W(RXE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push_src), .pop(host_rx_rd), .flush(rx_flush),
        .wdata(rx_wdata), .rdata(rx_head), .count(rx_cnt),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    for (genvar g = 0; g < TAG_W; g++) begin : g_tag
        serfifo_tagcnt #(.CW(CW), .OUTW(4)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc(rx_push_ok && rx_wdata[BYTE_W + g]),
            .dec(rx_pop_ok && rx_head[BYTE_W + g]),
            .clr(rx_flush),
            .full_cnt(tag_full[g]), .sat_cnt(tag_sat[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.ovr = (st_q.ovr && !ovr_clear) || (rx_push_src && !rx_push_ok && !rx_flush);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        count_word              = '0;
        count_word[8 +: CW]     = tx_cnt;
        count_word[0 +: CW]     = rx_cnt;
    end

    assign host_rx_data  = rx_head[BYTE_W-1:0];
    assign host_rx_ferr  = rx_head[BYTE_W];
    assign host_rx_perr  = rx_head[BYTE_W+1];
    assign fr_tx_data    = tx_head;
    assign fr_tx_avail   = (tx_cnt != '0);
    assign rx_full_flag  = 8'(rx_cnt) >= rx_level(cfg_rx_trig);
    assign tx_empty_flag = 8'(tx_cnt) <= tx_level(cfg_tx_trig);
    assign rts_stop      = cfg_flow_en && (8'(rx_cnt) > 8'(cfg_rts_lvl));
    assign ovr_flag      = st_q.ovr;
    assign ferr_count    = tag_sat[0];
    assign perr_count    = tag_sat[1];

    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag);
    p_tag_le_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_full[0] <= rx_cnt) && (tag_full[1] <= rx_cnt));
    p_rx_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_cnt == '0 && perr_count == '0 && ferr_count == '0));
    p_loop_isolate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loop && !fr_tx_pop && !host_rx_rd && !rx_flush) |=> $stable(rx_cnt));
endmodule

// File: tb/sim_serfifo_top.sv
module sim_serfifo_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        host_tx_wr = 0, host_rx_rd = 0, fr_tx_pop = 0, fr_rx_push = 0;
    logic [7:0]  host_tx_data = 0, fr_rx_data = 0;
    logic        fr_rx_perr = 0, fr_rx_ferr = 0;
    logic [1:0]  cfg_rx_trig = 0, cfg_tx_trig = 0;
    logic [4:0]  cfg_rts_lvl = 0;
    logic        cfg_flow_en = 0, cfg_loop = 0, tx_flush = 0, rx_flush = 0, ovr_clear = 0;
    logic [7:0]  host_rx_data, fr_tx_data;
    logic        host_rx_perr, host_rx_ferr, fr_tx_avail;
    logic        rx_full_flag, tx_empty_flag, rts_stop, ovr_flag;
    logic [15:0] count_word;
    logic [3:0]  perr_count, ferr_count;

    serfifo_top u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [9:0] rxq[$];   // {perr, ferr, data}
    bit ovr_m = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rx_lv(input int c);
        return c == 0 ? 1 : c == 1 ? 4 : c == 2 ? 8 : 14;
    endfunction
    function automatic int tx_lv(input int c);
        return c == 0 ? 8 : c == 1 ? 4 : c == 2 ? 2 : 1;
    endfunction
    function automatic int tagn(input int b);
        int n = 0;
        foreach (rxq[i]) n += rxq[i][b];
        return n > 15 ? 15 : n;
    endfunction

    task automatic check_state(input string tag);
        check({tag, " R7 count_word"}, count_word, (txq.size() << 8) | rxq.size());
        check({tag, " R5 rx_full"}, rx_full_flag, rxq.size() >= rx_lv(cfg_rx_trig));
        check({tag, " R6 tx_empty"}, tx_empty_flag, txq.size() <= tx_lv(cfg_tx_trig));
        check({tag, " R8 rts"}, rts_stop, cfg_flow_en && rxq.size() > cfg_rts_lvl);
        check({tag, " R3 ovr"}, ovr_flag, ovr_m);
        check({tag, " R9 perr"}, perr_count, tagn(9));
        check({tag, " R9 ferr"}, ferr_count, tagn(8));
        check({tag, " R1 avail"}, fr_tx_avail, txq.size() != 0);
    endtask

    // One cycle of traffic; drives at negedge, model updated from the requirements.
    task automatic op(input bit twr, input logic [7:0] tb, input bit tpop,
                      input bit rpush, input logic [9:0] rb, input bit rrd);
        logic [7:0] popped;
        bit tpop_ok, rpop_ok;
        if (tpop && txq.size() > 0) check("R1 tx head", fr_tx_data, txq[0]);
        if (rrd && rxq.size() > 0)
            check("R2 rx head", {host_rx_perr, host_rx_ferr, host_rx_data}, rxq[0]);
        host_tx_wr = twr; host_tx_data = tb; fr_tx_pop = tpop;
        fr_rx_push = rpush; {fr_rx_perr, fr_rx_ferr, fr_rx_data} = rb; host_rx_rd = rrd;
        @(negedge clk);
        host_tx_wr = 0; fr_tx_pop = 0; fr_rx_push = 0; host_rx_rd = 0;
        tpop_ok = tpop && txq.size() > 0;
        popped = tpop_ok ? txq.pop_front() : 8'h00;
        if (twr && (txq.size() < 16)) txq.push_back(tb);
        rpop_ok = rrd && rxq.size() > 0;
        if (rpop_ok) void'(rxq.pop_front());
        if (cfg_loop) begin
            if (tpop_ok) begin
                if (rxq.size() < 16) rxq.push_back({2'b00, popped}); else ovr_m = 1;
            end
        end else if (rpush) begin
            if (rxq.size() < 16) rxq.push_back(rb); else ovr_m = 1;
        end
    endtask

    task automatic sweep_flags(input string tag);
        for (int c = 0; c < 4; c++) begin
            cfg_rx_trig = c[1:0]; cfg_tx_trig = c[1:0]; #1;
            check({tag, " R5 rx_full"}, rx_full_flag, rxq.size() >= rx_lv(c));
            check({tag, " R6 tx_empty"}, tx_empty_flag, txq.size() <= tx_lv(c));
        end
        cfg_flow_en = 1;
        for (int l = 0; l < 17; l++) begin
            cfg_rts_lvl = l[4:0]; #1;
            check({tag, " R8 rts"}, rts_stop, rxq.size() > l);
        end
        cfg_flow_en = 0; #1;
        check({tag, " R8 rts off"}, rts_stop, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        check("R13 count", count_word, 0);
        check("R13 tx_empty", tx_empty_flag, 1);
        check("R13 rx_full", rx_full_flag, 0);
        check("R13 ovr", ovr_flag, 0);
        check("R13 rts", rts_stop, 0);
        check("R13 errs", {perr_count, ferr_count}, 0);

        // Transmit sweep to one past full, then drain in order.
        for (int n = 0; n < 17; n++) begin
            op(1, 8'(8'h30 + n), 0, 0, 0, 0);
            check_state("tx fill");
            sweep_flags("tx fill");
        end
        op(1, 8'hEE, 1, 0, 0, 0);           // write + pop at full
        check_state("R4 tx pair full");
        for (int n = 0; n < 6; n++) begin op(0, 0, 1, 0, 0, 0); check_state("tx drain"); end

        // Receive sweep with tag patterns, past full.
        for (int n = 0; n < 17; n++) begin
            op(0, 0, 0, 1, {n % 3 == 0, n % 5 == 0, 8'(8'h80 + n)}, 0);
            check_state("rx fill");
            sweep_flags("rx fill");
        end
        op(0, 0, 0, 0, 0, 0); check_state("R3 ovr sticky");
        op(0, 0, 0, 1, 10'h2A5, 1); check_state("R3 R4 rx pair full");
        for (int n = 0; n < 16; n++) begin op(0, 0, 0, 0, 0, 1); check_state("R2 rx drain"); end
        op(0, 0, 0, 0, 0, 1); check_state("R2 rx empty read");
        ovr_clear = 1; ovr_m = 0; op(0, 0, 0, 0, 0, 0); ovr_clear = 0;
        check_state("R3 clear");

        // Saturation: all 16 bytes carry both tags.
        for (int n = 0; n < 16; n++) op(0, 0, 0, 1, {2'b11, 8'(n)}, 0);
        check_state("R9 sat16");
        op(0, 0, 0, 0, 0, 1); check_state("R9 sat15");
        op(0, 0, 0, 0, 0, 1); check_state("R9 sat14");

        // Overrun then flush with a push the same cycle.
        op(0, 0, 0, 1, 10'h001, 0); op(0, 0, 0, 1, 10'h002, 0); op(0, 0, 0, 1, 10'h003, 0);
        check_state("R3 overfill");
        rx_flush = 1; fr_rx_push = 1; host_rx_rd = 1; @(negedge clk);
        rx_flush = 0; fr_rx_push = 0; host_rx_rd = 0; rxq.delete();
        check_state("R11 rx flush");

        // Transmit flush with a write and pop the same cycle.
        tx_flush = 1; host_tx_wr = 1; fr_tx_pop = 1; @(negedge clk);
        tx_flush = 0; host_tx_wr = 0; fr_tx_pop = 0; txq.delete();
        check_state("R10 tx flush");

        // Loopback with junk on the framer receive input.
        for (int n = 0; n < 4; n++) op(1, 8'(8'hC0 + n), 0, 0, 0, 0);
        cfg_loop = 1;
        op(0, 0, 0, 1, 10'h3FF, 0); check_state("R12 junk ignored");
        for (int n = 0; n < 4; n++) begin op(0, 0, 1, 1, 10'h3FF, 0); check_state("R12 loop"); end
        cfg_loop = 0;
        for (int n = 0; n < 4; n++) begin op(0, 0, 0, 0, 0, 1); check_state("R12 loop read"); end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule